// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt request lines and picks one of them to present to a processor on a single interrupt output. Software reaches it through a two-address register port. The command address takes initialization, end-of-interrupt, priority and read-select commands. The data address carries the initialization words and, once the block is running, the line mask. An acknowledge pulse returns an 8-bit vector: the programmed base plus the number of the winning line.

Three internal registers hold the state. The request register latches incoming requests. The in-service register tracks the lines that have been acknowledged and have not yet been ended. The mask register blocks individual lines. A short initialization sequence sets the vector base, a stored cascade word, and optionally a mode word. The first word of that sequence selects edge or level triggering for all lines. The mode word can enable automatic end-of-interrupt. Priority is fixed by default, with line 0 highest. A command can move the lowest-priority position to any line, which rotates the order.

Top module: `prio_intc`

## Requirements
- R1: A command-address write with bit 4 set starts initialization. In that cycle it clears the mask and in-service registers, resets priority to fixed order and selects the request register for reads. The next data-address writes are then taken in this order: the vector base, the cascade word, and the mode word. The mode word is taken only when bit 0 of the first word was set. After the sequence, data-address writes load the mask.
- R2: When the acknowledge pulse wins, the next cycle's vector equals the vector base plus the number of the winning line.
- R3: The cascade word is stored unchanged and has no other effect. After read-select code 01, a command-address read returns it.
- R4: Bit 1 of the mode word enables automatic end-of-interrupt: an acknowledge then leaves the in-service register unchanged.
- R5: A mask bit of 1 blocks its line from the interrupt output. A mask of 0xFF keeps the output low while requests are still latched. A data-address read returns the mask.
- R6: Command byte with bits 7:5 = 001 clears the highest-priority set in-service bit. Bits 7:5 = 011 clears the in-service bit named by bits 2:0. Both apply only when bits 4:3 are 00.
- R7: Command byte with bits 4:3 = 01 sets the read select from bits 1:0: 10 request register, 11 in-service register, 01 cascade word, 00 no change. Later command-address reads return the selected value, one cycle after the read strobe. Initialization restores the request-register selection.
- R8: Command byte with bits 7:5 = 110 makes the line in bits 2:0 the lowest priority. With level 2 the order is 3,4,5,6,7,0,1,2.
- R9: Bit 3 of the first initialization word selects level triggering. In level mode the request register follows the lines, and an acknowledge does not clear it. In edge mode a rising edge latches a request, the request is dropped if its line falls, and an acknowledge clears it.
- R10: An acknowledge while the interrupt output is low returns base plus 7 and leaves the in-service register unchanged.
- R11: The interrupt output is high only when some unmasked request outranks every set in-service bit. At acknowledge, the winner's in-service bit is set.
- R12: Reset clears the request and in-service registers and sets the mask to 0xFF. It sets priority to fixed order, with line 0 highest, and leaves the block ready with base 0 in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the command address, 1 selects the data address |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe; rdata_o updates on the next cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_i | input | N_LINES | Request lines |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge pulse, one cycle |
| vector_o | output | 8 | Vector captured at acknowledge |

## Verification
The resolver is tried with several request patterns. A lone request shows the base-plus-line vector. A higher line arriving while a lower one is in service shows nesting. A lower line arriving during service shows that it is held off until the matching end-of-interrupt. Two simultaneous requests under a moved lowest level separate rotated order from fixed order. A request that falls before acknowledge shows the spurious line-7 vector. Re-initializing into level mode with automatic end-of-interrupt shows a request that stays asserted after acknowledge. A shortened initialization, with no mode word, shows that the third data write lands in the mask.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [1:0] {
    SEQ_READY = 2'd0,
    SEQ_BASE  = 2'd1,
    SEQ_CASC  = 2'd2,
    SEQ_MODE  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RSEL_KEEP = 2'b00,
    RSEL_CASC = 2'b01,
    RSEL_IRR  = 2'b10,
    RSEL_ISR  = 2'b11
  } rsel_e;

  localparam int unsigned INIT_BIT = 4;
  localparam int unsigned SEL_BIT  = 3;
  localparam int unsigned MF_BIT   = 0;
  localparam int unsigned LVL_BIT  = 3;
  localparam int unsigned AEOI_BIT = 1;

  localparam logic [2:0] OP_EOI_ANY = 3'b001;
  localparam logic [2:0] OP_EOI_ONE = 3'b011;
  localparam logic [2:0] OP_SET_LOW = 3'b110;
endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic [LW-1:0]      lowest_i,
  output logic               found_o,
  output logic [LW-1:0]      idx_o
);
  // N_LINES must be a power of two: index wrap uses truncation
  logic [LW-1:0] line;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    line    = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      line = LW'(lowest_i + LW'(k + 1));
      if (req_i[line]) begin
        found_o = 1'b1;
        idx_o   = line;
      end
    end
  end
endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               level_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] irr_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic prev_q, irr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= req_i[g];
        if (level_i) irr_q <= req_i[g];
        else         irr_q <= (irr_q | (req_i[g] & ~prev_q)) & req_i[g] & ~clr_i[g];
      end
    end
    assign irr_o[g] = irr_q;
  end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic             dat_wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             ready_o,
  output logic             init_o,
  output logic             mask_wr_o,
  output logic [BUS_W-1:0] base_o,
  output logic [BUS_W-1:0] casc_o,
  output logic             aeoi_o,
  output logic             level_o
);
  seq_state_e state_q;
  logic       mf_q;

  assign ready_o   = (state_q == SEQ_READY);
  assign init_o    = cmd_wr_i & wdata_i[INIT_BIT];
  assign mask_wr_o = dat_wr_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_READY;
      mf_q    <= 1'b0;
      base_o  <= '0;
      casc_o  <= '0;
      aeoi_o  <= 1'b0;
      level_o <= 1'b0;
    end else if (init_o) begin
      state_q <= SEQ_BASE;
      mf_q    <= wdata_i[MF_BIT];
      level_o <= wdata_i[LVL_BIT];
      aeoi_o  <= 1'b0;
    end else if (dat_wr_i) begin
      unique case (state_q)
        SEQ_BASE: begin
          base_o  <= wdata_i;
          state_q <= SEQ_CASC;
        end
        SEQ_CASC: begin
          casc_o  <= wdata_i;
          state_q <= mf_q ? SEQ_MODE : SEQ_READY;
        end
        SEQ_MODE: begin
          aeoi_o  <= wdata_i[AEOI_BIT];
          state_q <= SEQ_READY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [N_LINES-1:0] irq_i,
  output logic               int_o,
  input  logic               inta_i,
  output logic [7:0]         vector_o
);
  localparam int unsigned LW = $clog2(N_LINES);
  localparam logic [LW-1:0] SPUR_LINE = LW'(N_LINES - 1);
  localparam logic [N_LINES-1:0] ONE_HOT0 = N_LINES'(1);

  logic cmd_wr, dat_wr;
  logic seq_ready, seq_init, seq_mask_wr, seq_aeoi, seq_level;
  logic [7:0] seq_base, seq_casc;

  assign cmd_wr = wr_i & ~addr_i;
  assign dat_wr = wr_i & addr_i;

  intc_init_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr),
    .dat_wr_i  (dat_wr),
    .wdata_i   (wdata_i),
    .ready_o   (seq_ready),
    .init_o    (seq_init),
    .mask_wr_o (seq_mask_wr),
    .base_o    (seq_base),
    .casc_o    (seq_casc),
    .aeoi_o    (seq_aeoi),
    .level_o   (seq_level)
  );

  logic [N_LINES-1:0] irr, isr_q, imr_q, ack_set, isr_set, isr_clr;
  logic [LW-1:0]      lowest_q;
  rsel_e              rsel_q;

  intc_req_latch #(.N_LINES(N_LINES)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (irq_i),
    .level_i (seq_level),
    .clr_i   (ack_set),
    .irr_o   (irr)
  );

  logic          p_found, s_found;
  logic [LW-1:0] p_idx, s_idx, p_rank, s_rank;

  intc_prio_pick #(.N_LINES(N_LINES)) u_pick_req (
    .req_i    (irr & ~imr_q),
    .lowest_i (lowest_q),
    .found_o  (p_found),
    .idx_o    (p_idx)
  );

  intc_prio_pick #(.N_LINES(N_LINES)) u_pick_isr (
    .req_i    (isr_q),
    .lowest_i (lowest_q),
    .found_o  (s_found),
    .idx_o    (s_idx)
  );

  // rank 0 is highest priority
  assign p_rank = LW'(p_idx - lowest_q - LW'(1));
  assign s_rank = LW'(s_idx - lowest_q - LW'(1));
  assign int_o  = seq_ready & p_found & (~s_found | (p_rank < s_rank));

  logic          ack_hit;
  logic [LW-1:0] ack_line;
  assign ack_hit  = inta_i & int_o;
  assign ack_line = ack_hit ? p_idx : SPUR_LINE;
  assign ack_set  = ack_hit ? (ONE_HOT0 << p_idx) : '0;
  assign isr_set  = seq_aeoi ? '0 : ack_set;

  logic          op_ok, sel_ok;
  logic [2:0]    op;
  logic [LW-1:0] op_lvl;
  assign op_ok  = cmd_wr & seq_ready & ~wdata_i[INIT_BIT] & ~wdata_i[SEL_BIT];
  assign sel_ok = cmd_wr & seq_ready & ~wdata_i[INIT_BIT] &  wdata_i[SEL_BIT];
  assign op     = wdata_i[7:5];
  assign op_lvl = wdata_i[LW-1:0];

  always_comb begin
    isr_clr = '0;
    if (op_ok && op == OP_EOI_ANY && s_found) isr_clr = ONE_HOT0 << s_idx;
    else if (op_ok && op == OP_EOI_ONE)       isr_clr = ONE_HOT0 << op_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      imr_q    <= '1;
      lowest_q <= SPUR_LINE;
      rsel_q   <= RSEL_IRR;
    end else if (seq_init) begin
      isr_q    <= '0;
      imr_q    <= '0;
      lowest_q <= SPUR_LINE;
      rsel_q   <= RSEL_IRR;
    end else begin
      isr_q <= (isr_q | isr_set) & ~isr_clr;
      if (seq_mask_wr) imr_q <= wdata_i[N_LINES-1:0];
      if (op_ok && op == OP_SET_LOW) lowest_q <= op_lvl;
      if (sel_ok && rsel_e'(wdata_i[1:0]) != RSEL_KEEP) rsel_q <= rsel_e'(wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_o <= '0;
      rdata_o  <= '0;
    end else begin
      if (inta_i) vector_o <= seq_base + 8'(ack_line);
      if (rd_i) begin
        if (addr_i) rdata_o <= 8'(imr_q);
        else begin
          unique case (rsel_q)
            RSEL_ISR:  rdata_o <= 8'(isr_q);
            RSEL_CASC: rdata_o <= seq_casc;
            default:   rdata_o <= 8'(irr);
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int unsigned N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               addr_i,
  input logic               inta_i,
  input logic               int_o,
  input logic [7:0]         wdata_i,
  input logic [7:0]         vector_o,
  input logic [7:0]         seq_base,
  input logic               seq_aeoi,
  input logic               seq_ready,
  input logic [N_LINES-1:0] isr_q,
  input logic [N_LINES-1:0] imr_q
);
  // R1
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i && wdata_i[4] |=> isr_q == '0 && imr_q == '0);

  // R10
  spur_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && !int_o && !wr_i |=> vector_o == $past(seq_base) + 8'(N_LINES - 1) && isr_q == $past(isr_q));

  // R4
  aeoi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && seq_aeoi && !wr_i |=> isr_q == $past(isr_q));

  // R6
  eoi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !addr_i && seq_ready && wdata_i[7:3] == 5'b00100 && isr_q != '0 && !inta_i
    |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  // R11
  isr_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> $countones(isr_q) <= $countones($past(isr_q)) + 1);

  // R5
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imr_q == '1 |-> !int_o);
endmodule

bind prio_intc prio_intc_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .inta_i    (inta_i),
  .int_o     (int_o),
  .wdata_i   (wdata_i),
  .vector_o  (vector_o),
  .seq_base  (seq_base),
  .seq_aeoi  (seq_aeoi),
  .seq_ready (seq_ready),
  .isr_q     (isr_q),
  .imr_q     (imr_q)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, irq = '0;
  logic [7:0] rdata, vector;
  logic       intr;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .int_o(intr),
    .inta_i(inta), .vector_o(vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R12 int low after reset", intr, 0);
    rd_reg(1'b1, d); chk("R12 mask after reset", d, 8'hFF);
    rd_reg(1'b0, d); chk("R12 irr after reset", d, 8'h00);
  endtask

  task automatic t_init_full();
    logic [7:0] d;
    wr_reg(1'b0, 8'h11); wr_reg(1'b1, 8'h20); wr_reg(1'b1, 8'h04); wr_reg(1'b1, 8'h00);
    rd_reg(1'b1, d); chk("R1 mask cleared by init", d, 8'h00);
    wr_reg(1'b0, 8'h09); rd_reg(1'b0, d); chk("R3 cascade readback", d, 8'h04);
    wr_reg(1'b0, 8'h0A);
  endtask

  task automatic t_mask_ack();
    logic [7:0] d;
    wr_reg(1'b1, 8'hFF);
    set_irq(8'h08);
    chk("R5 all masked keeps int low", intr, 0);
    rd_reg(1'b0, d); chk("R5 irr latched while masked", d, 8'h08);
    wr_reg(1'b1, 8'hF7);
    chk("R5 unmasked line raises int", intr, 1);
    ack();
    chk("R2 vector base+3", vector, 8'h23);
    chk("R11 int low while line in service", intr, 0);
    rd_reg(1'b0, d); chk("R9 edge irr cleared by ack", d, 8'h00);
    wr_reg(1'b0, 8'h0B); rd_reg(1'b0, d); chk("R7 isr select", d, 8'h08);
  endtask

  task automatic t_nesting();
    logic [7:0] d;
    wr_reg(1'b1, 8'h00);
    set_irq(8'h0A);
    chk("R11 higher line nests", intr, 1);
    ack();
    chk("R2 vector base+1", vector, 8'h21);
    rd_reg(1'b0, d); chk("R11 isr two bits", d, 8'h0A);
    set_irq(8'h2A);
    chk("R11 lower line held off", intr, 0);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, d); chk("R6 nonspecific eoi clears top", d, 8'h08);
    chk("R11 still held off by line 3", intr, 0);
    wr_reg(1'b0, 8'h63);
    rd_reg(1'b0, d); chk("R6 specific eoi line 3", d, 8'h00);
    chk("R11 line 5 now raises int", intr, 1);
    ack();
    chk("R2 vector base+5", vector, 8'h25);
    wr_reg(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_rotate();
    logic [7:0] d;
    wr_reg(1'b0, 8'hC2);
    set_irq(8'h12);
    chk("R8 int with two requests", intr, 1);
    ack();
    chk("R8 line 4 beats line 1", vector, 8'h24);
    chk("R8 line 1 below line 4", intr, 0);
    wr_reg(1'b0, 8'h20);
    chk("R8 line 1 after eoi", intr, 1);
    ack();
    chk("R8 vector base+1", vector, 8'h21);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, d); chk("R6 isr empty", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    set_irq(8'h40);
    chk("R9 edge latches", intr, 1);
    set_irq(8'h00);
    chk("R9 edge dropped when line falls", intr, 0);
    ack();
    chk("R10 spurious vector", vector, 8'h27);
    rd_reg(1'b0, d); chk("R10 isr untouched", d, 8'h00);
  endtask

  task automatic t_init_short();
    logic [7:0] d;
    wr_reg(1'b0, 8'h10); wr_reg(1'b1, 8'h80); wr_reg(1'b1, 8'h04); wr_reg(1'b1, 8'h5A);
    rd_reg(1'b1, d); chk("R1 third write is mask", d, 8'h5A);
    set_irq(8'h04);
    rd_reg(1'b0, d); chk("R7 default irr after init", d, 8'h04);
    ack();
    chk("R2 new base vector", vector, 8'h82);
    wr_reg(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_level_aeoi();
    logic [7:0] d;
    wr_reg(1'b0, 8'h19); wr_reg(1'b1, 8'h40); wr_reg(1'b1, 8'h02); wr_reg(1'b1, 8'h02);
    set_irq(8'h01);
    chk("R9 level request", intr, 1);
    ack();
    chk("R2 level vector", vector, 8'h40);
    chk("R9 level stays asserted", intr, 1);
    wr_reg(1'b0, 8'h0B); rd_reg(1'b0, d); chk("R4 auto eoi isr clear", d, 8'h00);
    set_irq(8'h00);
    chk("R9 level follows line", intr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_mask_ack();
    t_nesting();
    t_rotate();
    t_spurious();
    t_init_short();
    t_level_aeoi();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule